// File: doc/BRIEF.md
# Register-Programmed IO Pin Multiplexer

This block sits between a small group of physical IO cells and the peripheral functions that may use them. Each cell owns a select register. The value in that register picks which function drives the cell's output value and output enable, and which function receives the cell's input value. Select zero gives the cell to its own bit of a general-purpose IO function. Other codes give the cell to one of a shared set of peripheral functions. A function can be input-only, output-only or bidirectional. Only a bidirectional function supplies its own output enable.

Software programs the select registers through a simple single-cycle register port that carries an address, write data, read data and an error flag. The register index is a parameterised bit slice of the address. An access to an index with no cell behind it is flagged as an error. All routing is combinational from the select registers. A new select value takes effect in the cycle after the write. Every destination that no active selection drives reads as zero.

Top module: `pad_func_mux`

## Requirements
- R1: After reset every select register holds 0, `regRdData` is 0 and `regErr` is 0. As a result, every cell is routed to its general-purpose IO bit.
- R2: The cell index of an access is `regAddr[ADDR_HI:ADDR_LO]`, and all other address bits are ignored. An index below `NUM_CELLS` addresses that cell.
- R3: On a clock edge with `regWrEn` high and a valid index, the addressed select register takes `regWrData[SEL_W-1:0]`. The upper data bits are dropped.
- R4: In the cycle after `regRdEn` is high with a valid index, `regRdData` holds the addressed select value zero-extended, and `regErr` is 0. If a write to the same cell happens in the same cycle, the read returns the value from before the write. `regRdData` keeps its value in cycles without a read.
- R5: An access whose index is `NUM_CELLS` or above sets `regErr` in the next cycle and changes no register. If that access is a read, `regRdData` becomes 0. `regErr` is 0 in the cycle after any cycle that has no such access.
- R6: With select 0, cell c takes `padOut[c]=gpioOut[c]` and `padOe[c]=gpioOe[c]`, and `gpioIn[c]=padIn[c]`. With any other select, `gpioIn[c]` is 0.
- R7: A select value s in 1..NUM_FUNCS connects cell c to function f=(c+s-1) mod NUM_FUNCS. The function's kind is `FUNC_KIND[2f+1:2f]`: code 0 is input-only, code 1 is output-only, and codes 2 and 3 are bidirectional. For bidirectional kinds, `padOut[c]=fnOut[f]` and `padOe[c]=fnOe[f]`. For output-only, `padOut[c]=fnOut[f]` and `padOe[c]=1`. For input-only, both are 0.
- R8: `fnIn[f]` takes `padIn` from the lowest-numbered cell connected to f. It is 0 when no cell is connected to f or when f is output-only.
- R9: A select value above NUM_FUNCS drives `padOut` and `padOe` of that cell to 0 and delivers its pad input to no function.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regAddr | input | ADDR_W | Register address |
| regWrData | input | DATA_W | Write data |
| regRdData | output | DATA_W | Read data, registered |
| regErr | output | 1 | Error for the previous cycle's access |
| padIn | input | NUM_CELLS | Input values from the IO cells |
| padOut | output | NUM_CELLS | Output values to the IO cells |
| padOe | output | NUM_CELLS | Output enables to the IO cells |
| gpioOut | input | NUM_CELLS | General-purpose IO output bits |
| gpioOe | input | NUM_CELLS | General-purpose IO direction bits |
| gpioIn | output | NUM_CELLS | General-purpose IO input bits |
| fnOut | input | NUM_FUNCS | Peripheral function outputs |
| fnOe | input | NUM_FUNCS | Peripheral function output enables |
| fnIn | output | NUM_FUNCS | Peripheral function inputs |

## Verification
The bench builds the block with its defaults: four cells, a 2-bit select, two functions and a 3-bit address slice at bits 4..2. Function 0 is bidirectional and function 1 is output-only. The 3-bit slice leaves four indices with no cell behind them, so the error path can be reached. The 2-bit select leaves code 3 unmapped. Because cell index enters the mapping formula, two cells can claim the same function, which exercises the lowest-cell priority on the return path. The input-only kind is not present in this build.

// File: rtl/pmx_pkg.sv
`timescale 1ns/1ps
package pmx_pkg;

  localparam logic [1:0] KIND_IN_ONLY  = 2'd0;
  localparam logic [1:0] KIND_OUT_ONLY = 2'd1;

  // strobes from the address decoder to the register datapath
  typedef struct packed {
    logic wrHit;
    logic rdHit;
    logic rdMiss;
    logic anyMiss;
  } pmxStrobe_t;

endpackage

// File: rtl/pmx_ctrl.sv
`timescale 1ns/1ps
module pmx_ctrl
  import pmx_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int ADDR_LO   = 2,
  parameter int ADDR_HI   = 4,
  parameter int NUM_CELLS = 4,
  localparam int IDX_W    = ADDR_HI - ADDR_LO + 1
) (
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  output pmxStrobe_t        strobe,
  output logic [IDX_W-1:0]  cellIdx
);

  logic hit;
  logic unusedAddr;

  assign cellIdx    = regAddr[ADDR_HI:ADDR_LO];
  assign hit        = {1'b0, cellIdx} < (IDX_W+1)'(NUM_CELLS);
  assign unusedAddr = ^regAddr;

  always_comb begin
    strobe.wrHit   = regWrEn & hit;
    strobe.rdHit   = regRdEn & hit;
    strobe.rdMiss  = regRdEn & ~hit;
    strobe.anyMiss = (regWrEn | regRdEn) & ~hit;
  end

endmodule

// File: rtl/pmx_selregs.sv
`timescale 1ns/1ps
module pmx_selregs
  import pmx_pkg::*;
#(
  parameter int NUM_CELLS = 4,
  parameter int SEL_W     = 2,
  parameter int DATA_W    = 32,
  parameter int IDX_W     = 3
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  pmxStrobe_t                      strobe,
  input  logic [IDX_W-1:0]                cellIdx,
  input  logic [DATA_W-1:0]               wrData,
  output logic [NUM_CELLS-1:0][SEL_W-1:0] selVec,
  output logic [DATA_W-1:0]               regRdData,
  output logic                            regErr
);

  logic [SEL_W-1:0] rdSel;
  logic             unusedData;

  assign unusedData = ^wrData;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selVec <= '0;
    end else begin
      for (int c = 0; c < NUM_CELLS; c++) begin
        if (strobe.wrHit && cellIdx == IDX_W'(c)) selVec[c] <= wrData[SEL_W-1:0];
      end
    end
  end

  always_comb begin
    rdSel = '0;
    for (int c = 0; c < NUM_CELLS; c++) begin
      if (cellIdx == IDX_W'(c)) rdSel = selVec[c];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regRdData <= '0;
      regErr    <= 1'b0;
    end else begin
      regErr <= strobe.anyMiss;
      if (strobe.rdHit)       regRdData <= DATA_W'(rdSel);
      else if (strobe.rdMiss) regRdData <= '0;
    end
  end

  AST_MISS_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.anyMiss |=> $stable(selVec)); // R5
  AST_ERR_AFTER_MISS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.anyMiss |=> regErr); // R5
  AST_NO_ERR_ON_HIT: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.anyMiss |=> !regErr); // R5
  AST_READ_ZERO_EXT: assert property (@(posedge clk) disable iff (!rstN)
    strobe.rdHit |=> regRdData[DATA_W-1:SEL_W] == '0); // R4

  for (genvar g = 0; g < NUM_CELLS; g++) begin : gWrChk
    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.wrHit && cellIdx == IDX_W'(g)) |=> selVec[g] == $past(wrData[SEL_W-1:0])); // R3
  end

endmodule

// File: rtl/pmx_route.sv
`timescale 1ns/1ps
module pmx_route
  import pmx_pkg::*;
#(
  parameter int NUM_CELLS              = 4,
  parameter int SEL_W                  = 2,
  parameter int NUM_FUNCS              = 2,
  parameter logic [2*NUM_FUNCS-1:0] FUNC_KIND = '0,
  localparam int FN_W = (NUM_FUNCS > 1) ? $clog2(NUM_FUNCS) : 1
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic [NUM_CELLS-1:0][SEL_W-1:0] selVec,
  input  logic [NUM_CELLS-1:0]            padIn,
  output logic [NUM_CELLS-1:0]            padOut,
  output logic [NUM_CELLS-1:0]            padOe,
  input  logic [NUM_CELLS-1:0]            gpioOut,
  input  logic [NUM_CELLS-1:0]            gpioOe,
  output logic [NUM_CELLS-1:0]            gpioIn,
  input  logic [NUM_FUNCS-1:0]            fnOut,
  input  logic [NUM_FUNCS-1:0]            fnOe,
  output logic [NUM_FUNCS-1:0]            fnIn
);

  logic [NUM_CELLS-1:0]           cellMapped;
  logic [NUM_CELLS-1:0][FN_W-1:0] cellFn;

  // forward path: one steering block per cell
  for (genvar c = 0; c < NUM_CELLS; c++) begin : gCell
    always_comb begin
      int         fIdx;
      logic [1:0] kind;
      padOut[c]     = 1'b0;
      padOe[c]      = 1'b0;
      gpioIn[c]     = 1'b0;
      cellMapped[c] = 1'b0;
      cellFn[c]     = '0;
      fIdx          = (c + int'(selVec[c]) + NUM_FUNCS - 1) % NUM_FUNCS;
      kind          = FUNC_KIND[2*fIdx +: 2];
      if (selVec[c] == '0) begin
        padOut[c] = gpioOut[c];
        padOe[c]  = gpioOe[c];
        gpioIn[c] = padIn[c];
      end else if (int'(selVec[c]) <= NUM_FUNCS) begin
        cellMapped[c] = 1'b1;
        cellFn[c]     = FN_W'(fIdx);
        if (kind == KIND_OUT_ONLY) begin
          padOut[c] = fnOut[fIdx];
          padOe[c]  = 1'b1;
        end else if (kind != KIND_IN_ONLY) begin
          padOut[c] = fnOut[fIdx];
          padOe[c]  = fnOe[fIdx];
        end
      end
    end

    AST_UNMAPPED_QUIET: assert property (@(posedge clk) disable iff (!rstN)
      (int'(selVec[c]) > NUM_FUNCS) |-> (!padOut[c] && !padOe[c])); // R9
    AST_GPIO_IN_GATED: assert property (@(posedge clk) disable iff (!rstN)
      gpioIn[c] |-> (selVec[c] == '0 && padIn[c])); // R6
  end

  // return path: lowest-numbered claiming cell feeds each function
  always_comb begin
    logic [NUM_FUNCS-1:0] taken;
    taken = '0;
    fnIn  = '0;
    for (int c = 0; c < NUM_CELLS; c++) begin
      for (int f = 0; f < NUM_FUNCS; f++) begin
        if (cellMapped[c] && cellFn[c] == FN_W'(f) && !taken[f]) begin
          taken[f] = 1'b1;
          fnIn[f]  = (FUNC_KIND[2*f +: 2] == KIND_OUT_ONLY) ? 1'b0 : padIn[c];
        end
      end
    end
  end

  for (genvar f = 0; f < NUM_FUNCS; f++) begin : gFnChk
    AST_FN_IN_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
      fnIn[f] |-> (padIn != '0 && gpioIn != padIn)); // R8
  end

endmodule

// File: rtl/pad_func_mux.sv
`timescale 1ns/1ps
module pad_func_mux
  import pmx_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int ADDR_LO   = 2,
  parameter int ADDR_HI   = 4,
  parameter int NUM_CELLS = 4,
  parameter int SEL_W     = 2,
  parameter int NUM_FUNCS = 2,
  parameter logic [2*NUM_FUNCS-1:0] FUNC_KIND = 4'b01_10
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWrEn,
  input  logic                 regRdEn,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic [DATA_W-1:0]    regWrData,
  output logic [DATA_W-1:0]    regRdData,
  output logic                 regErr,
  input  logic [NUM_CELLS-1:0] padIn,
  output logic [NUM_CELLS-1:0] padOut,
  output logic [NUM_CELLS-1:0] padOe,
  input  logic [NUM_CELLS-1:0] gpioOut,
  input  logic [NUM_CELLS-1:0] gpioOe,
  output logic [NUM_CELLS-1:0] gpioIn,
  input  logic [NUM_FUNCS-1:0] fnOut,
  input  logic [NUM_FUNCS-1:0] fnOe,
  output logic [NUM_FUNCS-1:0] fnIn
);

  localparam int IDX_W = ADDR_HI - ADDR_LO + 1;

  pmxStrobe_t                      strobe;
  logic [IDX_W-1:0]                cellIdx;
  logic [NUM_CELLS-1:0][SEL_W-1:0] selVec;

  pmx_ctrl #(
    .ADDR_W(ADDR_W), .ADDR_LO(ADDR_LO), .ADDR_HI(ADDR_HI), .NUM_CELLS(NUM_CELLS)
  ) ctrl_i (
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr),
    .strobe(strobe), .cellIdx(cellIdx)
  );

  pmx_selregs #(
    .NUM_CELLS(NUM_CELLS), .SEL_W(SEL_W), .DATA_W(DATA_W), .IDX_W(IDX_W)
  ) regs_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cellIdx(cellIdx),
    .wrData(regWrData), .selVec(selVec), .regRdData(regRdData), .regErr(regErr)
  );

  pmx_route #(
    .NUM_CELLS(NUM_CELLS), .SEL_W(SEL_W), .NUM_FUNCS(NUM_FUNCS), .FUNC_KIND(FUNC_KIND)
  ) route_i (
    .clk(clk), .rstN(rstN), .selVec(selVec), .padIn(padIn),
    .padOut(padOut), .padOe(padOe), .gpioOut(gpioOut), .gpioOe(gpioOe),
    .gpioIn(gpioIn), .fnOut(fnOut), .fnOe(fnOe), .fnIn(fnIn)
  );

endmodule

// File: tb/pad_func_mux_tb_top.sv
`timescale 1ns/1ps
module pad_func_mux_tb_top;

  localparam int NC = 4;
  localparam int SW = 2;
  localparam int NF = 2;
  localparam int AW = 8;
  localparam int DW = 32;
  localparam logic [2*NF-1:0] KIND = 4'b01_10;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          regWrEn = 1'b0, regRdEn = 1'b0;
  logic [AW-1:0] regAddr = '0;
  logic [DW-1:0] regWrData = '0;
  logic [DW-1:0] regRdData;
  logic          regErr;
  logic [NC-1:0] padIn = '0, gpioOut = '0, gpioOe = '0;
  logic [NC-1:0] padOut, padOe, gpioIn;
  logic [NF-1:0] fnOut = '0, fnOe = '0, fnIn;

  int nChecks = 0;
  int nFail = 0;
  logic [SW-1:0] mdl [NC];

  always #2 clk = ~clk;

  pad_func_mux dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData), .regErr(regErr),
    .padIn(padIn), .padOut(padOut), .padOe(padOe),
    .gpioOut(gpioOut), .gpioOe(gpioOe), .gpioIn(gpioIn),
    .fnOut(fnOut), .fnOe(fnOe), .fnIn(fnIn)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doWrite(logic [AW-1:0] a, logic [DW-1:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic doRead(logic [AW-1:0] a, output logic [DW-1:0] d, output logic e);
    @(negedge clk);
    regRdEn = 1'b1; regAddr = a;
    @(negedge clk);
    regRdEn = 1'b0;
    d = regRdData; e = regErr;
  endtask

  // expected routing derived from R6..R9
  task automatic checkRoute(string tag);
    logic [NC-1:0] eOut, eOe, eGpio;
    logic [NF-1:0] eFn, taken;
    #1;
    eOut = '0; eOe = '0; eGpio = '0; eFn = '0; taken = '0;
    for (int c = 0; c < NC; c++) begin
      if (mdl[c] == 0) begin
        eOut[c] = gpioOut[c]; eOe[c] = gpioOe[c]; eGpio[c] = padIn[c];
      end else if (int'(mdl[c]) <= NF) begin
        int f;
        logic [1:0] k;
        f = (c + int'(mdl[c]) - 1) % NF;
        k = KIND[2*f +: 2];
        if (k == 2'd1) begin eOut[c] = fnOut[f]; eOe[c] = 1'b1; end
        else if (k != 2'd0) begin eOut[c] = fnOut[f]; eOe[c] = fnOe[f]; end
        if (!taken[f]) begin
          taken[f] = 1'b1;
          eFn[f] = (k == 2'd1) ? 1'b0 : padIn[c];
        end
      end
    end
    chk({tag, " padOut"}, 32'(padOut), 32'(eOut));
    chk({tag, " padOe"}, 32'(padOe), 32'(eOe));
    chk({tag, " gpioIn"}, 32'(gpioIn), 32'(eGpio));
    chk({tag, " fnIn"}, 32'(fnIn), 32'(eFn));
  endtask

  task automatic drivePattern(int p);
    logic [15:0] h;
    h = 16'(p * 40503 + 12345);
    gpioOut = h[3:0]; gpioOe = h[7:4]; padIn = h[11:8];
    fnOut = h[13:12]; fnOe = h[15:14];
  endtask

  task automatic testReset();
    logic [DW-1:0] d; logic e;
    chk("R1 rdData at reset", regRdData, 0);
    chk("R1 err at reset", 32'(regErr), 0);
    for (int c = 0; c < NC; c++) mdl[c] = '0;
    for (int p = 0; p < 4; p++) begin
      drivePattern(p);
      checkRoute("R1 R6 reset gpio routing");
    end
    for (int c = 0; c < NC; c++) begin
      doRead(AW'(c * 4), d, e);
      chk("R1 select resets to 0", d, 0);
    end
  endtask

  task automatic testWriteRead();
    logic [DW-1:0] d; logic e;
    for (int c = 0; c < NC; c++) begin
      doWrite(AW'(c * 4), 32'hFFFF_FFF0 | 32'((c + 1) % 4));
      mdl[c] = SW'((c + 1) % 4);
    end
    for (int c = 0; c < NC; c++) begin
      doRead(AW'(c * 4), d, e);
      chk("R3 R4 truncate and zero-extend", d, 32'((c + 1) % 4));
      chk("R4 err clear on valid read", 32'(e), 0);
    end
    // R2: bits outside the slice are ignored
    doWrite(8'hE1, 32'd2); mdl[0] = 2'd2;
    doRead(8'h62, d, e);
    chk("R2 slice decode cell0", d, 2);
    doRead(8'h0C, d, e);
    chk("R2 other cell untouched", d, 32'(mdl[3]));
    @(negedge clk);
    chk("R4 rdData holds when idle", regRdData, 32'(mdl[3]));
  endtask

  task automatic testMiss();
    logic [DW-1:0] d; logic e;
    doWrite(8'h10, 32'd3);
    chk("R5 err after write miss", 32'(regErr), 1);
    @(negedge clk);
    chk("R5 err clears when idle", 32'(regErr), 0);
    doWrite(8'h1C, 32'd1);
    chk("R5 err after write miss idx7", 32'(regErr), 1);
    for (int c = 0; c < NC; c++) begin
      doRead(AW'(c * 4), d, e);
      chk("R5 miss write changes nothing", d, 32'(mdl[c]));
    end
    doRead(8'h18, d, e);
    chk("R5 miss read data 0", d, 0);
    chk("R5 miss read err", 32'(e), 1);
  endtask

  task automatic testRouting();
    doWrite(8'h00, 1); mdl[0] = 2'd1;
    doWrite(8'h04, 1); mdl[1] = 2'd1;
    doWrite(8'h08, 2); mdl[2] = 2'd2;
    doWrite(8'h0C, 3); mdl[3] = 2'd3;
    for (int p = 0; p < 8; p++) begin
      drivePattern(p + 10);
      checkRoute("R7 R8 R9 function routing");
    end
    // R9 explicit: unmapped cell3 quiet even with all sources high
    gpioOut = '1; gpioOe = '1; fnOut = '1; fnOe = '1; padIn = '1;
    #1;
    chk("R9 unmapped padOut", 32'(padOut[3]), 0);
    chk("R9 unmapped padOe", 32'(padOe[3]), 0);
    chk("R6 gpioIn gated off", 32'(gpioIn), 0);
    chk("R7 output-only oe forced", 32'(padOe[1]), 1);
  endtask

  task automatic testPriority();
    // cell0 s=1 -> f0, cell1 s=2 -> f0, both claim function 0
    doWrite(8'h04, 2); mdl[1] = 2'd2;
    padIn = 4'b0010; fnOut = '0; fnOe = 2'b01;
    #1;
    chk("R8 lowest cell wins (low)", 32'(fnIn[0]), 0);
    padIn = 4'b0001;
    #1;
    chk("R8 lowest cell wins (high)", 32'(fnIn[0]), 1);
    chk("R7 bidir oe follows function", 32'(padOe[1:0]), 32'(2'b11));
    for (int p = 0; p < 4; p++) begin
      drivePattern(p + 30);
      checkRoute("R8 shared function");
    end
  endtask

  task automatic testSameCycle();
    logic [DW-1:0] d; logic e;
    @(negedge clk);
    regWrEn = 1'b1; regRdEn = 1'b1; regAddr = 8'h08; regWrData = 32'd1;
    @(negedge clk);
    regWrEn = 1'b0; regRdEn = 1'b0;
    chk("R4 same-cycle read sees old value", regRdData, 32'(mdl[2]));
    mdl[2] = 2'd1;
    doRead(8'h08, d, e);
    chk("R3 same-cycle write landed", d, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testWriteRead();
    testMiss();
    testRouting();
    testPriority();
    testSameCycle();
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

endmodule